// File: doc/BRIEF.md
# Sign-Logarithm Multiply and Power Unit

This unit performs the cheap half of logarithmic arithmetic on operands held as a sign bit and a base-2 logarithm. The logarithm is a 20-bit two's-complement fixed-point value, read as 8 integer bits and 12 fractional bits. Products and quotients come from one adder or subtractor. Squares and square roots come from one-bit shifts. Reciprocals come from negation. Because these are exact integer operations on the logarithm, exact inputs give exact results and no rounding error is added. The one exception is the square root of a code with an odd least significant bit, where the right shift truncates toward minus infinity.

A sixth operation multiplies a dual-redundant value by a sign/logarithm value. The dual-redundant value carries one logarithm for its positive part and another for its negative part. The multiplier's logarithm is added to both parts by two adders that work in parallel. When the multiplier is negative, the two results trade places.

The fractional point position does not affect any operation, so the width is the only real parameter. A result that leaves the logarithm range saturates to the nearest end of the range and raises a flag. Every result is registered and appears one cycle after a valid input, together with an output strobe.

Top module: `slog_mulpow`

## Requirements
- R1: With op = 0 (multiply), r_sign = a_sign XOR b_sign and r_log = a_log + b_log.
- R2: With op = 1 (divide), r_sign = a_sign XOR b_sign and r_log = a_log - b_log.
- R3: With op = 2 (reciprocal), r_sign = a_sign and r_log = -a_log.
- R4: With op = 3 (square), r_sign = 0 and r_log = 2 * a_log.
- R5: With op = 4 (square root) and a_sign = 0, r_sign = 0 and r_log = floor(a_log / 2), which is an arithmetic right shift by one.
- R6: With op = 4 and a_sign = 1, inv = 1, r_sign = 0 and r_log = 20'h80000, the smallest code, which stands for zero magnitude. inv is 0 for every other operation.
- R7: With op = 5 (mixed multiply), the positive part is a_log + b_log and the negative part is a_neg_log + b_log. When b_sign = 0, r_log carries the positive part and r_neg_log the negative part. When b_sign = 1, the two are exchanged. r_sign = 0. For ops 0 to 4, r_neg_log = 0.
- R8: A result above 20'h7FFFF becomes 20'h7FFFF and sets ovf = 1.
- R9: A result below -524288 becomes 20'h80000 and sets unf = 1.
- R10: Results and flags register one clock after in_valid = 1, and out_valid is in_valid delayed by one clock. While in_valid = 0 the result registers hold their values. Reset (rst_n = 0) clears all outputs to 0.
- R11: Opcodes 6 and 7 are reserved. They give r_sign = 0, r_log = 0, r_neg_log = 0 and all flags 0, and out_valid still pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operands and opcode are valid this cycle |
| op | input | 3 | Operation select (0 mul, 1 div, 2 recip, 3 square, 4 sqrt, 5 mixed) |
| a_sign | input | 1 | Sign of operand A |
| a_log | input | 20 | Logarithm of A; positive part for mixed multiply |
| a_neg_log | input | 20 | Negative-part logarithm of A for mixed multiply |
| b_sign | input | 1 | Sign of operand B (the multiplier) |
| b_log | input | 20 | Logarithm of B |
| out_valid | output | 1 | Result registers were loaded on the last edge |
| r_sign | output | 1 | Result sign |
| r_log | output | 20 | Result logarithm, or positive part for mixed multiply |
| r_neg_log | output | 20 | Negative-part result for mixed multiply, else 0 |
| ovf | output | 1 | Logarithm saturated high |
| unf | output | 1 | Logarithm saturated low |
| inv | output | 1 | Square root of a negative operand |

## Verification
Directed stimulus applies each operation to operands of both signs, including negative logarithms. This separates a sum from a difference and an XOR of the signs from an OR. Cases at the edges of the range push sums, doubled values and the negation of the smallest code past the limits, which shows whether the unit saturates or wraps. Odd negative codes under square root show whether the shift is arithmetic or logical. Mixed multiplies with each multiplier sign show whether the parts are swapped. A long run of random operands and opcodes, interleaved with idle cycles, is then compared every clock against a behavioural model, which also checks that the outputs hold and that the strobe timing is right.

// File: rtl/slog_pkg.sv
// Shared definitions for the sign-logarithm multiply/power unit.
// Assumes the logarithm is two's complement; the fractional point does not matter.
package slog_pkg;
    parameter int LOG_W = 20;

    typedef enum logic [2:0] {
        OP_MUL    = 3'd0,
        OP_DIV    = 3'd1,
        OP_RECIP  = 3'd2,
        OP_SQUARE = 3'd3,
        OP_SQRT   = 3'd4,
        OP_MIXED  = 3'd5
    } slog_op_e;
endpackage

// File: rtl/slog_sat_addsub.sv
// Saturating two's-complement adder/subtractor for logarithm fields.
// Computes x + y, or x - y when sub is set, with one extra bit.
// Clamps to the largest or smallest code and flags which end it hit.
module slog_sat_addsub #(
    parameter int W = 20
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         sub,
    output logic [W-1:0] res,
    output logic         ovf,
    output logic         unf
);
    localparam logic [W-1:0] MAX_CODE = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] MIN_CODE = {1'b1, {(W-1){1'b0}}};

    logic [W:0] ext;

    // Extended sum, then range check on the two top bits.
    always_comb begin
        if (sub) ext = {x[W-1], x} - {y[W-1], y};
        else     ext = {x[W-1], x} + {y[W-1], y};
        ovf = (ext[W:W-1] == 2'b01);
        unf = (ext[W:W-1] == 2'b10);
        if (ovf)      res = MAX_CODE;
        else if (unf) res = MIN_CODE;
        else          res = ext[W-1:0];
    end
endmodule

// File: rtl/slog_unary.sv
// Single-operand logarithm operations: square (double), square root
// (arithmetic halve) and reciprocal (negate), all computed in parallel.
// Assumes the caller selects one result; saturation comes from slog_sat_addsub.
module slog_unary #(
    parameter int W = 20
) (
    input  logic [W-1:0] x,
    output logic [W-1:0] sq_log,
    output logic         sq_ovf,
    output logic         sq_unf,
    output logic [W-1:0] rt_log,
    output logic [W-1:0] rc_log,
    output logic         rc_ovf,
    output logic         rc_unf
);
    localparam logic [W-1:0] ZERO = '0;

    // Square: x + x is a left shift by one, with saturation.
    slog_sat_addsub #(.W(W)) u_sq (
        .x(x), .y(x), .sub(1'b0),
        .res(sq_log), .ovf(sq_ovf), .unf(sq_unf)
    );

    // Reciprocal: 0 - x; only the smallest code can overflow.
    slog_sat_addsub #(.W(W)) u_rc (
        .x(ZERO), .y(x), .sub(1'b1),
        .res(rc_log), .ovf(rc_ovf), .unf(rc_unf)
    );

    // Square root: arithmetic right shift by one (floor).
    always_comb rt_log = {x[W-1], x[W-1:1]};
endmodule

// File: rtl/slog_mixed_mul.sv
// Dual-redundant times sign/log multiply: the multiplier logarithm is added
// to the positive and negative parts by two parallel saturating adders.
// A negative multiplier exchanges the two parts on the way out.
module slog_mixed_mul #(
    parameter int W = 20
) (
    input  logic [W-1:0] pos_log,
    input  logic [W-1:0] neg_log,
    input  logic         m_sign,
    input  logic [W-1:0] m_log,
    output logic [W-1:0] out_pos,
    output logic [W-1:0] out_neg,
    output logic         ovf,
    output logic         unf
);
    localparam int PARTS = 2;

    logic [W-1:0] part_in  [PARTS];
    logic [W-1:0] part_out [PARTS];
    logic [PARTS-1:0] part_ovf;
    logic [PARTS-1:0] part_unf;

    // Gather the two parts so one adder instance serves each.
    always_comb begin
        part_in[0] = pos_log;
        part_in[1] = neg_log;
    end

    for (genvar gi = 0; gi < PARTS; gi++) begin : g_part
        slog_sat_addsub #(.W(W)) u_add (
            .x(part_in[gi]), .y(m_log), .sub(1'b0),
            .res(part_out[gi]), .ovf(part_ovf[gi]), .unf(part_unf[gi])
        );
    end

    // Swap multiplexers driven by the multiplier sign; merge flags.
    always_comb begin
        out_pos = m_sign ? part_out[1] : part_out[0];
        out_neg = m_sign ? part_out[0] : part_out[1];
        ovf     = |part_ovf;
        unf     = |part_unf;
    end
endmodule

// File: rtl/slog_mulpow.sv
// Sign-logarithm multiply/divide/reciprocal/square/square-root unit with a
// mixed dual-redundant multiply. One register stage: results appear one
// clock after in_valid. Assumes a synchronous active-low reset.
module slog_mulpow #(
    parameter int LOG_W = slog_pkg::LOG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [2:0]       op,
    input  logic             a_sign,
    input  logic [LOG_W-1:0] a_log,
    input  logic [LOG_W-1:0] a_neg_log,
    input  logic             b_sign,
    input  logic [LOG_W-1:0] b_log,
    output logic             out_valid,
    output logic             r_sign,
    output logic [LOG_W-1:0] r_log,
    output logic [LOG_W-1:0] r_neg_log,
    output logic             ovf,
    output logic             unf,
    output logic             inv
);
    import slog_pkg::*;

    localparam logic [LOG_W-1:0] MIN_CODE = {1'b1, {(LOG_W-1){1'b0}}};

    logic [LOG_W-1:0] md_log;
    logic             md_ovf, md_unf;
    logic [LOG_W-1:0] sq_log, rt_log, rc_log;
    logic             sq_ovf, sq_unf, rc_ovf, rc_unf;
    logic [LOG_W-1:0] mx_pos, mx_neg;
    logic             mx_ovf, mx_unf;
    logic             is_div;

    logic             n_sign, n_ovf, n_unf, n_inv;
    logic [LOG_W-1:0] n_log, n_neg;

    // Divide reuses the multiply adder in subtract mode.
    always_comb is_div = (op == OP_DIV);

    slog_sat_addsub #(.W(LOG_W)) u_muldiv (
        .x(a_log), .y(b_log), .sub(is_div),
        .res(md_log), .ovf(md_ovf), .unf(md_unf)
    );

    slog_unary #(.W(LOG_W)) u_unary (
        .x(a_log),
        .sq_log(sq_log), .sq_ovf(sq_ovf), .sq_unf(sq_unf),
        .rt_log(rt_log),
        .rc_log(rc_log), .rc_ovf(rc_ovf), .rc_unf(rc_unf)
    );

    slog_mixed_mul #(.W(LOG_W)) u_mixed (
        .pos_log(a_log), .neg_log(a_neg_log),
        .m_sign(b_sign), .m_log(b_log),
        .out_pos(mx_pos), .out_neg(mx_neg),
        .ovf(mx_ovf), .unf(mx_unf)
    );

    // Opcode selection of the next result and its flags.
    always_comb begin
        n_sign = 1'b0;
        n_log  = '0;
        n_neg  = '0;
        n_ovf  = 1'b0;
        n_unf  = 1'b0;
        n_inv  = 1'b0;
        case (op)
            OP_MUL, OP_DIV: begin
                n_sign = a_sign ^ b_sign;
                n_log  = md_log;
                n_ovf  = md_ovf;
                n_unf  = md_unf;
            end
            OP_RECIP: begin
                n_sign = a_sign;
                n_log  = rc_log;
                n_ovf  = rc_ovf;
                n_unf  = rc_unf;
            end
            OP_SQUARE: begin
                n_log  = sq_log;
                n_ovf  = sq_ovf;
                n_unf  = sq_unf;
            end
            OP_SQRT: begin
                n_inv  = a_sign;
                n_log  = a_sign ? MIN_CODE : rt_log;
            end
            OP_MIXED: begin
                n_log  = mx_pos;
                n_neg  = mx_neg;
                n_ovf  = mx_ovf;
                n_unf  = mx_unf;
            end
            default: ;
        endcase
    end

    // Output register: load on in_valid, hold otherwise, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            r_sign    <= 1'b0;
            r_log     <= '0;
            r_neg_log <= '0;
            ovf       <= 1'b0;
            unf       <= 1'b0;
            inv       <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                r_sign    <= n_sign;
                r_log     <= n_log;
                r_neg_log <= n_neg;
                ovf       <= n_ovf;
                unf       <= n_unf;
                inv       <= n_inv;
            end
        end
    end
endmodule

// File: rtl/slog_mulpow_chk.sv
// Assertion checker for slog_mulpow, attached by bind.
// Assumes the port meanings stated in the brief.
module slog_mulpow_chk #(
    parameter int LOG_W = 20
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [2:0]       op,
    input logic             a_sign,
    input logic             b_sign,
    input logic             out_valid,
    input logic             r_sign,
    input logic [LOG_W-1:0] r_log,
    input logic [LOG_W-1:0] r_neg_log,
    input logic             ovf,
    input logic             unf,
    input logic             inv
);
    localparam logic [LOG_W-1:0] MAX_CODE = {1'b0, {(LOG_W-1){1'b1}}};
    localparam logic [LOG_W-1:0] MIN_CODE = {1'b1, {(LOG_W-1){1'b0}}};

    AST_VALID_PIPE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R10
    AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R10
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(r_log) && $stable(r_neg_log) && $stable(r_sign))); // R10
    AST_MUL_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 3'd0) |=> (r_sign == $past(a_sign ^ b_sign))); // R1
    AST_SQRT_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 3'd4 && a_sign) |=> (inv && r_log == MIN_CODE && !r_sign)); // R6
    AST_INV_SQRT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op != 3'd4) |=> !inv); // R6
    AST_OVF_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && ovf) |-> (r_log == MAX_CODE || r_neg_log == MAX_CODE)); // R8
    AST_UNF_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && unf) |-> (r_log == MIN_CODE || r_neg_log == MIN_CODE)); // R9
    AST_ONE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op != 3'd5) |=> !(ovf && unf)); // R8
    AST_RESERVED_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op[2:1] == 2'b11) |=> (r_log == '0 && !ovf && !unf && !r_sign)); // R11
endmodule

bind slog_mulpow slog_mulpow_chk #(.LOG_W(LOG_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
    .a_sign(a_sign), .b_sign(b_sign), .out_valid(out_valid),
    .r_sign(r_sign), .r_log(r_log), .r_neg_log(r_neg_log),
    .ovf(ovf), .unf(unf), .inv(inv)
);

// File: tb/slog_mulpow_test.sv
// Self-checking bench: behavioural integer model, compared every clock.
module slog_mulpow_test;
    localparam int W = 20;
    localparam int LMAX = 524287;
    localparam int LMIN = -524288;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [2:0] op = '0;
    logic a_sign = 1'b0, b_sign = 1'b0;
    logic [W-1:0] a_log = '0, a_neg_log = '0, b_log = '0;
    logic out_valid, r_sign, ovf, unf, inv;
    logic [W-1:0] r_log, r_neg_log;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Expected (held) output state of the model.
    logic e_valid = 0, e_sign = 0, e_ovf = 0, e_unf = 0, e_inv = 0;
    logic [W-1:0] e_log = '0, e_neg = '0;

    always #2.5 clk = ~clk;

    slog_mulpow uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
        .a_sign(a_sign), .a_log(a_log), .a_neg_log(a_neg_log),
        .b_sign(b_sign), .b_log(b_log), .out_valid(out_valid),
        .r_sign(r_sign), .r_log(r_log), .r_neg_log(r_neg_log),
        .ovf(ovf), .unf(unf), .inv(inv)
    );

    function automatic logic [W-1:0] sat(input int v, inout logic o, inout logic u);
        if (v > LMAX) begin o = 1; return W'(LMAX); end
        if (v < LMIN) begin u = 1; return W'(LMIN); end
        return W'(v);
    endfunction

    task automatic check(input string tag);
        checks++;
        if ({out_valid, r_sign, r_log, r_neg_log, ovf, unf, inv} !==
            {e_valid, e_sign, e_log, e_neg, e_ovf, e_unf, e_inv}) begin
            errors++;
            $display("FAIL %s: got v=%b s=%b log=%h neg=%h o=%b u=%b i=%b expected v=%b s=%b log=%h neg=%h o=%b u=%b i=%b",
                tag, out_valid, r_sign, r_log, r_neg_log, ovf, unf, inv,
                e_valid, e_sign, e_log, e_neg, e_ovf, e_unf, e_inv);
        end
    endtask

    // Drive one cycle at a falling edge, update the model, compare next falling edge.
    task automatic step(input bit v, input logic [2:0] o, input logic as, input logic [W-1:0] al,
                        input logic [W-1:0] anl, input logic bs, input logic [W-1:0] bl,
                        input string tag);
        int a, an, b;
        in_valid = v; op = o; a_sign = as; a_log = al; a_neg_log = anl;
        b_sign = bs; b_log = bl;
        a = int'($signed(al)); an = int'($signed(anl)); b = int'($signed(bl));
        e_valid = v;
        if (v) begin
            e_sign = 0; e_log = '0; e_neg = '0; e_ovf = 0; e_unf = 0; e_inv = 0;
            case (o)
                3'd0: begin e_sign = as ^ bs; e_log = sat(a + b, e_ovf, e_unf); end
                3'd1: begin e_sign = as ^ bs; e_log = sat(a - b, e_ovf, e_unf); end
                3'd2: begin e_sign = as; e_log = sat(-a, e_ovf, e_unf); end
                3'd3: e_log = sat(2 * a, e_ovf, e_unf);
                3'd4: begin
                    if (as) begin e_inv = 1; e_log = W'(LMIN); end
                    else e_log = W'(a >>> 1);
                end
                3'd5: begin
                    logic [W-1:0] p, n;
                    p = sat(a + b, e_ovf, e_unf);
                    n = sat(an + b, e_ovf, e_unf);
                    e_log = bs ? n : p;
                    e_neg = bs ? p : n;
                end
                default: ;
            endcase
        end
        @(negedge clk);
        check(tag);
    endtask

    initial begin
        #(5ns * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R10 reset");
        rst_n = 1'b1;
        // R1 multiply
        step(1, 3'd0, 1, 20'h01000, 0, 0, 20'h00800, "R1 mul mixed signs");
        step(1, 3'd0, 1, 20'hFD000, 0, 1, 20'h01234, "R1 mul negative log");
        // R2 divide
        step(1, 3'd1, 0, 20'h02000, 0, 1, 20'h05000, "R2 div");
        // R3 reciprocal
        step(1, 3'd2, 1, 20'h04321, 0, 0, 0, "R3 recip");
        step(1, 3'd2, 0, 20'hF0000, 0, 0, 0, "R3 recip negative");
        // R4 square
        step(1, 3'd3, 1, 20'h01800, 0, 0, 0, "R4 square");
        // R5 square root
        step(1, 3'd4, 0, 20'h03000, 0, 0, 0, "R5 sqrt");
        step(1, 3'd4, 0, 20'hFFFFD, 0, 0, 0, "R5 sqrt odd negative floor");
        // R6 invalid square root
        step(1, 3'd4, 1, 20'h01000, 0, 0, 0, "R6 sqrt negative operand");
        // R7 mixed multiply, both multiplier signs
        step(1, 3'd5, 0, 20'h01000, 20'h02000, 0, 20'h00100, "R7 mixed positive");
        step(1, 3'd5, 0, 20'h01000, 20'h02000, 1, 20'h00100, "R7 mixed swap");
        // R8 overflow
        step(1, 3'd0, 0, 20'h7F000, 0, 0, 20'h01000, "R8 mul overflow");
        step(1, 3'd2, 0, 20'h80000, 0, 0, 0, "R8 recip of min");
        step(1, 3'd3, 0, 20'h50000, 0, 0, 0, "R8 square overflow");
        step(1, 3'd5, 0, 20'h7FF00, 20'h00000, 1, 20'h00200, "R8 mixed overflow swapped");
        // R9 underflow
        step(1, 3'd0, 0, 20'h81000, 0, 0, 20'hFE000, "R9 mul underflow");
        step(1, 3'd1, 0, 20'h81000, 0, 0, 20'h02000, "R9 div underflow");
        step(1, 3'd3, 0, 20'hB0000, 0, 0, 0, "R9 square underflow");
        // R11 reserved opcodes
        step(1, 3'd6, 1, 20'h12345, 20'h11111, 1, 20'h00001, "R11 reserved 6");
        step(1, 3'd7, 0, 20'h12345, 20'h11111, 0, 20'h00001, "R11 reserved 7");
        // R10 hold while idle
        step(1, 3'd0, 0, 20'h00011, 0, 0, 20'h00022, "R1 before idle");
        step(0, 3'd3, 1, 20'h55555, 20'h33333, 1, 20'h44444, "R10 idle hold");
        step(0, 3'd5, 0, 20'h00000, 20'h00000, 0, 20'h00000, "R10 idle hold 2");
        // Random mix with idle cycles
        for (int i = 0; i < 600; i++) begin
            logic [2:0] ro;
            string t;
            ro = 3'($urandom_range(0, 7));
            case (ro)
                3'd0: t = "R1 random"; 3'd1: t = "R2 random";
                3'd2: t = "R3 random"; 3'd3: t = "R4 random";
                3'd4: t = "R5 random"; 3'd5: t = "R7 random";
                default: t = "R11 random";
            endcase
            step(($urandom_range(0, 3) != 0), ro, 1'($urandom), W'($urandom),
                 W'($urandom), 1'($urandom), W'($urandom), t);
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule